// File: doc/BRIEF.md
# Breakpoint Extended-Value Access Trap Decoder

This block decides what happens when software reads or writes the extended value register of a hardware breakpoint through the coprocessor-style system register path. A request comes with a breakpoint index, the current privilege level (0 to 3), a set of implemented-feature flags, the debug trap controls owned by the hypervisor level (level 2) and the monitor level (level 3), the OS-lock state, a halting-permitted flag and the external debugger's software-access trap bit. The decoder walks a priority chain that depends on the level. It picks exactly one of six outcomes: undefined instruction, trap to level 2 through the 64-bit route, trap to level 2 through the 32-bit hypervisor route, trap to level 3, halt into debug state, or perform the access.

The outcome is registered one cycle after the request. It is shown as a one-hot vector, together with a syndrome class code for the trap outcomes and a register write or read strobe when the access goes ahead. The breakpoint register storage itself sits outside this block. A read and a write go through the same decision. They differ only in which strobe fires.

A small two-state machine holds the response. `ST_IDLE` shows no outcome. `ST_SHOW` presents the outcome captured on the previous edge. The transition `GO_SHOW` (ST_IDLE to ST_SHOW) is taken on a valid request. `HOLD_SHOW` (ST_SHOW to ST_SHOW) is taken on a back-to-back request. `GO_IDLE` (ST_SHOW to ST_IDLE) is taken when no request is present.

Top module: `bxv_trap_decoder`

## Requirements
- R1: After reset, and until the first request, `out_valid`, `outcome`, `syn_class`, `reg_wr_stb` and `reg_rd_stb` are all zero.
- R2: The outcome is undefined (outcome bit 0) at any level when `has_l1_narrow` is 0 or `req_idx` is at or above `NUM_BKPT`.
- R3: A request from level 0 (`cur_lvl` = 0) is always undefined.
- R4: At levels 1 and 2, when `l3_undef_first`, `l3_present`, `l3_wide` and `l3_trap_dbg` are all 1, the outcome is undefined, even if a level 2 trap is also armed.
- R5: At level 1, when `l2_enabled` is 1 and either `l2_route_dbg` or `l2_trap_dbg` is 1, the request traps to level 2. If `l2_wide` is 1 this uses the 64-bit route (outcome bit 1). Otherwise it uses the hypervisor route (outcome bit 2). Both routes report `syn_class` = 0x05.
- R6: At levels 1 and 2, after the earlier checks, when `l3_present`, `l3_wide` and `l3_trap_dbg` are all 1, the outcome is undefined if `l3_undef_sel` is 1. Otherwise it traps to level 3 (outcome bit 3) with `syn_class` = 0x05.
- R7: At levels 1, 2 and 3, after the earlier checks, when `os_locked` is 0, `halt_ok` is 1 and `ext_trap_sw` is 1, the outcome is halt (outcome bit 4).
- R8: If no earlier check applies, the outcome is access (outcome bit 5). `reg_wr_stb` is 1 for a write (`req_write` = 1) and `reg_rd_stb` is 1 for a read. Both strobes are 0 for every other outcome. `syn_class` is 0 for every non-trap outcome.
- R9: At level 2 the level 2 trap controls have no effect. At level 3 only the halt check of R7 applies, and every trap control is ignored.
- R10: The outputs appear on the clock edge after a request. While `out_valid` is 1, exactly one outcome bit is set. When no request was present on the previous edge, `out_valid` and `outcome` are 0.
- R11: With identical inputs, a read and a write produce the same outcome and `syn_class`. `reg_idx` presents the requested index alongside the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W | Breakpoint index |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| has_l1_narrow | input | 1 | 32-bit level 1 execution is implemented |
| l2_enabled | input | 1 | Level 2 is present and enabled |
| l2_wide | input | 1 | Level 2 runs in 64-bit state |
| l3_present | input | 1 | Level 3 is implemented |
| l3_wide | input | 1 | Level 3 runs in 64-bit state |
| l3_undef_first | input | 1 | Level 3 undefined takes priority over level 2 traps |
| l3_undef_sel | input | 1 | Level 3 debug trap becomes undefined instead of a trap |
| l2_route_dbg | input | 1 | Level 2 routes debug exceptions to itself |
| l2_trap_dbg | input | 1 | Level 2 traps debug register accesses |
| l3_trap_dbg | input | 1 | Level 3 traps debug register accesses |
| os_locked | input | 1 | OS lock is set |
| halt_ok | input | 1 | Halting is currently permitted |
| ext_trap_sw | input | 1 | External debugger traps software accesses |
| out_valid | output | 1 | Outcome valid |
| outcome | output | 6 | One-hot outcome |
| syn_class | output | 6 | Syndrome class for trap outcomes |
| reg_wr_stb | output | 1 | Write the selected register |
| reg_rd_stb | output | 1 | Read the selected register |
| reg_idx | output | IDX_W | Index registered with the outcome |

## Verification
The hardest situation to reach from the ports is a request where several checks would fire at once and only the ordering decides the result. One example is a level 2 trap armed together with a level 3 undefined-first condition. Another is level 3 trap bits set while the core runs at level 3. The stimulus table builds these on purpose. Each row starts from a baseline in which every level is present and 64-bit, then turns on two or three competing conditions together, so the outcome shows which check wins. Back-to-back rows keep the machine in `ST_SHOW`, and a final idle cycle drives the `GO_IDLE` transition.

// File: rtl/bxv_pkg.sv
package bxv_pkg;

    localparam int OC_W     = 6;
    localparam int EC_W     = 6;
    localparam logic [EC_W-1:0] TRAP_EC = 6'h05;

    typedef enum logic [OC_W-1:0] {
        OC_NONE   = 6'b000000,
        OC_UNDEF  = 6'b000001,
        OC_TRAP2W = 6'b000010,
        OC_TRAP2H = 6'b000100,
        OC_TRAP3  = 6'b001000,
        OC_HALT   = 6'b010000,
        OC_ACCESS = 6'b100000
    } outcome_e;

    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2,
        LVL_3 = 2'd3
    } lvl_e;

    typedef struct packed {
        logic l1_narrow;
        logic l2_on;
        logic l2_wide;
        logic l3_on;
        logic l3_wide;
        logic l3_undef_first;
        logic l3_undef_sel;
        logic l2_route;
        logic l2_trap;
        logic l3_trap;
        logic os_locked;
        logic halt_ok;
        logic ext_trap;
    } trap_ctl_t;

endpackage

// File: rtl/bxv_prio_chain.sv
module bxv_prio_chain
    import bxv_pkg::*;
#(
    parameter int NUM_BKPT = 12,
    parameter int IDX_W    = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       lvl,
    input  trap_ctl_t        ctl,
    output outcome_e         dec
);

    localparam logic [IDX_W:0] IDX_LIMIT = NUM_BKPT[IDX_W:0];

    logic idx_ok;
    logic l3_armed;
    logic l3_early_undef;
    logic l2_armed;
    logic halt_hit;
    lvl_e lvl_q;

    assign lvl_q          = lvl_e'(lvl);
    assign idx_ok         = ({1'b0, idx} < IDX_LIMIT);
    assign l3_armed       = ctl.l3_on && ctl.l3_wide && ctl.l3_trap;
    assign l3_early_undef = l3_armed && ctl.l3_undef_first;
    assign l2_armed       = ctl.l2_on && (ctl.l2_route || ctl.l2_trap);
    assign halt_hit       = !ctl.os_locked && ctl.halt_ok && ctl.ext_trap;

    always_comb begin
        dec = OC_ACCESS;
        if (!ctl.l1_narrow || !idx_ok) begin
            dec = OC_UNDEF;
        end else begin
            unique case (lvl_q)
                LVL_0: dec = OC_UNDEF;
                LVL_1: begin
                    if (l3_early_undef)            dec = OC_UNDEF;
                    else if (l2_armed && ctl.l2_wide)  dec = OC_TRAP2W;
                    else if (l2_armed)             dec = OC_TRAP2H;
                    else if (l3_armed)             dec = ctl.l3_undef_sel ? OC_UNDEF : OC_TRAP3;
                    else if (halt_hit)             dec = OC_HALT;
                    else                           dec = OC_ACCESS;
                end
                LVL_2: begin
                    if (l3_early_undef)            dec = OC_UNDEF;
                    else if (l3_armed)             dec = ctl.l3_undef_sel ? OC_UNDEF : OC_TRAP3;
                    else if (halt_hit)             dec = OC_HALT;
                    else                           dec = OC_ACCESS;
                end
                LVL_3: begin
                    if (halt_hit)                  dec = OC_HALT;
                    else                           dec = OC_ACCESS;
                end
                default: dec = OC_UNDEF;
            endcase
        end
    end

endmodule

// File: rtl/bxv_resp_fsm.sv
module bxv_resp_fsm
    import bxv_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_idx,
    input  outcome_e         dec,
    output logic             out_valid,
    output logic [OC_W-1:0]  outcome,
    output logic [EC_W-1:0]  syn_class,
    output logic             wr_stb,
    output logic             rd_stb,
    output logic [IDX_W-1:0] idx_q
);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } resp_state_e;

    resp_state_e state;
    resp_state_e state_nx;
    logic [EC_W-1:0] ec_nx;
    logic is_access;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_SHOW;
            ST_SHOW: if (!req_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign is_access = (dec == OC_ACCESS);

    always_comb begin
        unique case (dec)
            OC_TRAP2W, OC_TRAP2H, OC_TRAP3: ec_nx = TRAP_EC;
            default:                        ec_nx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            outcome   <= '0;
            syn_class <= '0;
            wr_stb    <= 1'b0;
            rd_stb    <= 1'b0;
            idx_q     <= '0;
        end else begin
            outcome   <= dec;
            syn_class <= ec_nx;
            wr_stb    <= is_access && req_write;
            rd_stb    <= is_access && !req_write;
            idx_q     <= req_idx;
        end
    end

    assign out_valid = (state == ST_SHOW);

endmodule

// File: rtl/bxv_trap_decoder.sv
module bxv_trap_decoder
    import bxv_pkg::*;
#(
    parameter int NUM_BKPT = 12,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [1:0]       cur_lvl,
    input  logic             has_l1_narrow,
    input  logic             l2_enabled,
    input  logic             l2_wide,
    input  logic             l3_present,
    input  logic             l3_wide,
    input  logic             l3_undef_first,
    input  logic             l3_undef_sel,
    input  logic             l2_route_dbg,
    input  logic             l2_trap_dbg,
    input  logic             l3_trap_dbg,
    input  logic             os_locked,
    input  logic             halt_ok,
    input  logic             ext_trap_sw,
    output logic             out_valid,
    output logic [5:0]       outcome,
    output logic [5:0]       syn_class,
    output logic             reg_wr_stb,
    output logic             reg_rd_stb,
    output logic [IDX_W-1:0] reg_idx
);

    trap_ctl_t ctl;
    outcome_e  dec;

    assign ctl = '{
        l1_narrow:      has_l1_narrow,
        l2_on:          l2_enabled,
        l2_wide:        l2_wide,
        l3_on:          l3_present,
        l3_wide:        l3_wide,
        l3_undef_first: l3_undef_first,
        l3_undef_sel:   l3_undef_sel,
        l2_route:       l2_route_dbg,
        l2_trap:        l2_trap_dbg,
        l3_trap:        l3_trap_dbg,
        os_locked:      os_locked,
        halt_ok:        halt_ok,
        ext_trap:       ext_trap_sw
    };

    bxv_prio_chain #(
        .NUM_BKPT (NUM_BKPT),
        .IDX_W    (IDX_W)
    ) u_chain (
        .idx (req_idx),
        .lvl (cur_lvl),
        .ctl (ctl),
        .dec (dec)
    );

    bxv_resp_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_idx   (req_idx),
        .dec       (dec),
        .out_valid (out_valid),
        .outcome   (outcome),
        .syn_class (syn_class),
        .wr_stb    (reg_wr_stb),
        .rd_stb    (reg_rd_stb),
        .idx_q     (reg_idx)
    );

endmodule

// File: rtl/bxv_trap_chk.sv
module bxv_trap_chk #(
    parameter int NUM_BKPT = 12,
    parameter int IDX_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic [1:0]       cur_lvl,
    input logic             out_valid,
    input logic [5:0]       outcome,
    input logic [5:0]       syn_class,
    input logic             reg_wr_stb,
    input logic             reg_rd_stb
);

    localparam logic [IDX_W:0] IDX_LIMIT = NUM_BKPT[IDX_W:0];

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(outcome) == 1);

    // R10
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (outcome == 6'd0 && !reg_wr_stb && !reg_rd_stb));

    // R10
    one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R3
    lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_lvl == 2'd0) |=> outcome == 6'b000001);

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && {1'b0, req_idx} >= IDX_LIMIT) |=> outcome == 6'b000001);

    // R8
    strobe_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_stb || reg_rd_stb) |-> (outcome[5] && !(reg_wr_stb && reg_rd_stb)));

    // R5
    trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (outcome[1] || outcome[2] || outcome[3])) |-> syn_class == 6'h05);

    // R8
    nontrap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(outcome[1] || outcome[2] || outcome[3])) |-> syn_class == 6'h00);

endmodule

bind bxv_trap_decoder bxv_trap_chk #(
    .NUM_BKPT (NUM_BKPT),
    .IDX_W    (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_idx    (req_idx),
    .cur_lvl    (cur_lvl),
    .out_valid  (out_valid),
    .outcome    (outcome),
    .syn_class  (syn_class),
    .reg_wr_stb (reg_wr_stb),
    .reg_rd_stb (reg_rd_stb)
);

// File: tb/tb_bxv_trap_decoder.sv
module tb_bxv_trap_decoder;

    localparam int IDX_W = 4;
    localparam logic [5:0] U   = 6'b000001;
    localparam logic [5:0] T2W = 6'b000010;
    localparam logic [5:0] T2H = 6'b000100;
    localparam logic [5:0] T3  = 6'b001000;
    localparam logic [5:0] H   = 6'b010000;
    localparam logic [5:0] A   = 6'b100000;

    // {wr, idx[3:0], lvl[1:0], flags[12:0], expected[5:0]}
    // flags: narrow | l2en l2wide | l3p l3wide l3uf l3us | l2route l2trap l3trap | oslock haltok ext
    localparam int NV = 20;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 4'd3,  2'd1, 13'b1_11_1100_000_000, A  },  // R8 write access
        {1'b0, 4'd3,  2'd1, 13'b1_11_1100_000_000, A  },  // R11 read access
        {1'b0, 4'd3,  2'd1, 13'b0_11_1100_000_000, U  },  // R2 no 32-bit level 1
        {1'b0, 4'd12, 2'd1, 13'b1_11_1100_000_000, U  },  // R2 index at limit
        {1'b1, 4'd11, 2'd1, 13'b1_11_1100_000_000, A  },  // R2 last valid index
        {1'b0, 4'd2,  2'd0, 13'b1_11_1100_000_000, U  },  // R3 level 0
        {1'b0, 4'd1,  2'd1, 13'b1_11_1110_101_000, U  },  // R4 beats level 2 trap
        {1'b0, 4'd1,  2'd1, 13'b1_11_1100_010_000, T2W},  // R5 64-bit route
        {1'b1, 4'd1,  2'd1, 13'b1_10_1100_100_000, T2H},  // R5 hypervisor route
        {1'b0, 4'd1,  2'd1, 13'b1_01_1100_011_000, T3 },  // R6 level 2 disabled
        {1'b0, 4'd1,  2'd1, 13'b1_11_1101_001_000, U  },  // R6 undef select
        {1'b0, 4'd1,  2'd1, 13'b1_11_1000_001_011, H  },  // R7 level 3 narrow
        {1'b0, 4'd1,  2'd1, 13'b1_11_1100_000_111, A  },  // R7 os lock blocks halt
        {1'b0, 4'd5,  2'd2, 13'b1_11_1100_111_000, T3 },  // R9 level 2 ignores l2 bits
        {1'b1, 4'd5,  2'd2, 13'b1_11_1100_110_000, A  },  // R9 level 2 only l2 bits
        {1'b0, 4'd5,  2'd2, 13'b1_11_1110_001_000, U  },  // R4 at level 2
        {1'b0, 4'd7,  2'd3, 13'b1_11_1111_111_000, A  },  // R9 level 3 ignores traps
        {1'b1, 4'd7,  2'd3, 13'b1_11_1111_111_011, H  },  // R7 halt at level 3
        {1'b0, 4'd4,  2'd1, 13'b1_11_0100_001_000, A  },  // R6 no level 3
        {1'b1, 4'd4,  2'd2, 13'b1_11_1100_001_000, T3 }   // R11 write trap
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [IDX_W-1:0] req_idx = '0;
    logic [1:0] cur_lvl = '0;
    logic [12:0] flags = '0;
    logic out_valid, reg_wr_stb, reg_rd_stb;
    logic [5:0] outcome, syn_class;
    logic [IDX_W-1:0] reg_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bxv_trap_decoder dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_idx        (req_idx),
        .cur_lvl        (cur_lvl),
        .has_l1_narrow  (flags[12]),
        .l2_enabled     (flags[11]),
        .l2_wide        (flags[10]),
        .l3_present     (flags[9]),
        .l3_wide        (flags[8]),
        .l3_undef_first (flags[7]),
        .l3_undef_sel   (flags[6]),
        .l2_route_dbg   (flags[5]),
        .l2_trap_dbg    (flags[4]),
        .l3_trap_dbg    (flags[3]),
        .os_locked      (flags[2]),
        .halt_ok        (flags[1]),
        .ext_trap_sw    (flags[0]),
        .out_valid      (out_valid),
        .outcome        (outcome),
        .syn_class      (syn_class),
        .reg_wr_stb     (reg_wr_stb),
        .reg_rd_stb     (reg_rd_stb),
        .reg_idx        (reg_idx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [5:0] e;
        logic [5:0] ec;
        logic w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 outcome",   32'(outcome),   32'd0);
        check("R1 strobes",   32'({reg_wr_stb, reg_rd_stb, syn_class}), 32'd0);

        for (int i = 0; i < NV; i++) begin
            w         = VEC[i][25];
            req_valid = 1'b1;
            req_write = w;
            req_idx   = VEC[i][24:21];
            cur_lvl   = VEC[i][20:19];
            flags     = VEC[i][18:6];
            e         = VEC[i][5:0];
            ec        = (e == T2W || e == T2H || e == T3) ? 6'h05 : 6'h00;
            @(negedge clk);
            // R10 registered one cycle later
            check($sformatf("R10 valid row %0d", i), 32'(out_valid), 32'd1);
            check($sformatf("R2-chain outcome row %0d", i), 32'(outcome), 32'(e));
            check($sformatf("R5 R6 R8 class row %0d", i), 32'(syn_class), 32'(ec));
            check($sformatf("R8 strobes row %0d", i), 32'({reg_wr_stb, reg_rd_stb}),
                  32'({(e == A) && w, (e == A) && !w}));
            check($sformatf("R11 index row %0d", i), 32'(reg_idx), 32'(VEC[i][24:21]));
        end

        // R10 idle cycle clears outputs
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 idle valid",   32'(out_valid), 32'd0);
        check("R10 idle outcome", 32'(outcome),   32'd0);

        // R11 same inputs, read then write in successive cycles
        req_valid = 1'b1; req_write = 1'b0; req_idx = 4'd9; cur_lvl = 2'd1;
        flags = 13'b1_10_1100_010_000;
        @(negedge clk);
        check("R11 read outcome", 32'({outcome, syn_class}), 32'({T2H, 6'h05}));
        req_write = 1'b1;
        @(negedge clk);
        check("R11 write outcome", 32'({outcome, syn_class}), 32'({T2H, 6'h05}));
        check("R8 no strobe on trap", 32'({reg_wr_stb, reg_rd_stb}), 32'd0);

        // R1 reset during activity
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset", 32'({out_valid, outcome, reg_wr_stb, reg_rd_stb}), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule